// File: doc/BRIEF.md
# EPROM Fast Programming Sequencer

This controller burns a byte-wide UV-erasable or one-time-programmable ROM using an adaptive pulse-and-verify routine. After a start request it raises the core and programming supplies in a safe order, walks every address, applies fixed-width program strobes, and reads each byte back until it matches the source. A byte is abandoned after a fixed number of strobes. A second sweep re-reads every location and gives any byte that has drifted one extra strobe. Two read-only margin sweeps then follow, at reduced supply levels.

The image to be written comes from a source that returns, in the same cycle, the byte for the address currently on `rom_addr`. The analog supplies are outside the block. The sequencer only requests levels through two 2-bit codes, `core_lvl` and `prog_lvl`. Every delay is set by a clock-frequency parameter, and each one is rounded up to whole cycles. When the run ends, both supplies return to nominal, and the block reports success or failure. A failure carries the address that failed and the phase in which it failed.

Top module: `eprom_burn_seq`

## Requirements
- R1: `start` is taken only while `busy` is low. Taking it raises `busy`, clears `done` and `fail`, and begins the run at address 0. A `start` pulse while `busy` is high has no effect on the run, its strobe count or its result.
- R2: Supply codes are shared by both rails: 00 = nominal 5.0 V (the programming rail follows the core), 01 = programming level (6.5 V core, 12.75 V programming rail), 10 = 6.0 V, 11 = 4.3 V. `prog_lvl` becomes 01 only after `core_lvl` is already 01. The two codes never change in the same cycle. When `core_lvl` steps down to a level, `prog_lvl` already holds that level.
- R3: A program strobe is `rom_ce_n` low with `rom_oe_n` high. It lasts exactly PULSE_NS rounded up to cycles, with `rom_wdata_en` high and both supply codes at 01.
- R4: Before a strobe falls, `rom_addr` and `rom_wdata` have been steady for at least SETUP_NS of cycles, and so has `prog_lvl`. Both stay steady, with `rom_wdata_en` high, for at least SETUP_NS of cycles after the strobe rises.
- R5: Each read holds `rom_oe_n` low for exactly READ_NS rounded up to cycles, with `rom_wdata_en` low. During the programming sweeps the read is taken with `rom_ce_n` high. In the first sweep a match moves to the next address and clears the strobe count.
- R6: In the first sweep a byte that still mismatches after MAX_PULSES strobes ends the run with `fail`. `fail_phase` is then 00 and `fail_addr` holds that address.
- R7: After the last address the second sweep re-reads every byte starting at address 0. A mismatching byte gets exactly one extra strobe and no re-read, and then the address advances.
- R8: The margin sweeps read every byte with `rom_ce_n` and `rom_oe_n` low. The first runs with both codes at 10 and the second with both at 11. A mismatch ends the run with `fail`, with `fail_phase` equal to the sweep's code (10 or 11) and `fail_addr` holding that address.
- R9: At the end of a run `prog_lvl` drops first and `core_lvl` follows. Both end at 00. Then `busy` falls, and exactly one of `done` and `fail` rises. The result holds until the next accepted start.
- R10: During reset `busy`, `done`, `fail` and `rom_wdata_en` are low, `rom_ce_n` and `rom_oe_n` are high, and both supply codes are 00.
- R11: Each cycle count is the ceiling of CLK_HZ times the duration. At 2.5 MHz this gives 125 cycles for a 50 µs strobe, 3 cycles for 1 µs and 1 cycle for 150 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, taken while idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run completed with every check passing |
| fail | output | 1 | Last run ended with a failure |
| fail_phase | output | 2 | Phase of the failure: 00 first sweep, 10 margin at 6.0 V, 11 margin at 4.3 V |
| fail_addr | output | ADDR_W | Address of the failing byte |
| rom_addr | output | ADDR_W | Address to the ROM and to the image source |
| src_data | input | DATA_W | Image byte for `rom_addr` |
| rom_wdata | output | DATA_W | Byte driven onto the ROM data pins |
| rom_wdata_en | output | 1 | Enable for the data pin drivers |
| rom_rdata | input | DATA_W | Byte read back from the ROM |
| rom_ce_n | output | 1 | Chip enable and program strobe, active low |
| rom_oe_n | output | 1 | Output enable, active low |
| core_lvl | output | 2 | Requested core supply code |
| prog_lvl | output | 2 | Requested programming supply code |

## Verification
Several rules are checked on every cycle. A strobe happens only at programming levels with output enable high. The data drivers are never on while the ROM outputs. Address and data stay frozen across a strobe. The programming rail rises only above a raised core, and the core never leaves programming level while the programming rail is still there. No first-sweep strobe exceeds the cap, and done and fail are never both high.

Other behaviour shows up only in whole runs against a bench model of the ROM. That model needs a set number of strobes per byte, can lose a byte before the second sweep, and can misread one byte at reduced supply. These runs show the exact strobe totals, the failing phase and address, the rounded strobe and setup widths, and that a repeated start is ignored.

// File: rtl/eprom_burn_seq.sv
module eprom_burn_seq #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int MAX_PULSES = 10,
  parameter int PULSE_NS   = 50_000,
  parameter int SETUP_NS   = 1_000,
  parameter int READ_NS    = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [1:0]        fail_phase,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [DATA_W-1:0] rom_wdata,
  output logic              rom_wdata_en,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic [1:0]        core_lvl,
  output logic [1:0]        prog_lvl
);

  function automatic int to_cyc(input longint ns);
    return int'((longint'(CLK_HZ) * ns + 64'sd999_999_999) / 64'sd1_000_000_000);
  endfunction

  localparam int PULSE_CYC = to_cyc(longint'(PULSE_NS));
  localparam int SETUP_CYC = to_cyc(longint'(SETUP_NS));
  localparam int READ_CYC  = to_cyc(longint'(READ_NS));
  localparam int SR_MAX    = (SETUP_CYC > READ_CYC) ? SETUP_CYC : READ_CYC;
  localparam int T_MAX     = (PULSE_CYC > SR_MAX) ? PULSE_CYC : SR_MAX;
  localparam int TW        = $clog2(T_MAX + 1);
  localparam int PW        = $clog2(MAX_PULSES + 1);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  localparam logic [1:0] LV_NOM = 2'b00, LV_PRG = 2'b01, LV_HI = 2'b10, LV_LO = 2'b11;
  localparam logic [1:0] PH_P1 = 2'b00, PH_P2 = 2'b01;

  typedef enum logic [3:0] {
    S_IDLE, S_VUP, S_PUP, S_SET, S_PUL, S_HLD, S_VFY, S_RAIL, S_CORE, S_MRD
  } st_t;

  function automatic logic [TW-1:0] span(input st_t s);
    case (s)
      S_IDLE:       return '0;
      S_PUL:        return TW'(PULSE_CYC - 1);
      S_VFY, S_MRD: return TW'(READ_CYC - 1);
      default:      return TW'(SETUP_CYC - 1);
    endcase
  endfunction

  st_t st, n_st;
  logic [TW-1:0]     tmr;
  logic [ADDR_W-1:0] adr, n_adr, n_fad;
  logic [PW-1:0]     pc, n_pc;
  logic [1:0]        ph, n_ph, tgt, n_tgt, core, n_core, prog, n_prog, n_fph;
  logic              bad, n_bad, n_done, n_fail;
  logic              match, last;

  assign match        = (rom_rdata == src_data);
  assign last         = (adr == LAST);
  assign busy         = (st != S_IDLE);
  assign rom_addr     = adr;
  assign rom_wdata    = src_data;
  assign rom_wdata_en = (st == S_SET) || (st == S_PUL) || (st == S_HLD);
  assign rom_ce_n     = !((st == S_PUL) || (st == S_MRD));
  assign rom_oe_n     = !((st == S_VFY) || (st == S_MRD));
  assign core_lvl     = core;
  assign prog_lvl     = prog;

  always_comb begin
    n_st = st; n_adr = adr; n_pc = pc; n_ph = ph; n_tgt = tgt;
    n_core = core; n_prog = prog; n_bad = bad;
    n_done = done; n_fail = fail; n_fph = fail_phase; n_fad = fail_addr;
    case (st)
      S_IDLE: if (start) begin
        n_st = S_VUP; n_core = LV_PRG; n_adr = '0; n_pc = '0; n_ph = PH_P1;
        n_bad = 1'b0; n_done = 1'b0; n_fail = 1'b0;
      end
      S_VUP: begin n_st = S_PUP; n_prog = LV_PRG; end
      S_PUP: n_st = S_SET;
      S_SET: n_st = S_PUL;
      S_PUL: begin n_st = S_HLD; n_pc = pc + 1'b1; end
      S_HLD:
        if (ph != PH_P2) n_st = S_VFY;
        else if (last) begin n_tgt = LV_HI; n_prog = LV_HI; n_st = S_RAIL; end
        else begin n_adr = adr + 1'b1; n_st = S_VFY; end
      S_VFY:
        if (ph == PH_P1) begin
          if (match) begin
            n_pc = '0;
            if (last) begin n_ph = PH_P2; n_adr = '0; end
            else begin n_adr = adr + 1'b1; n_st = S_SET; end
          end else if (pc == PW'(MAX_PULSES)) begin
            n_bad = 1'b1; n_fph = PH_P1; n_fad = adr;
            n_tgt = LV_NOM; n_prog = LV_NOM; n_st = S_RAIL;
          end else n_st = S_SET;
        end else begin
          if (!match) n_st = S_SET;
          else if (last) begin n_tgt = LV_HI; n_prog = LV_HI; n_st = S_RAIL; end
          else n_adr = adr + 1'b1;
        end
      S_RAIL: begin n_core = tgt; n_st = S_CORE; end
      S_CORE:
        if (tgt == LV_NOM) begin n_st = S_IDLE; n_done = !bad; n_fail = bad; end
        else begin n_st = S_MRD; n_adr = '0; n_ph = tgt; end
      S_MRD:
        if (!match) begin
          n_bad = 1'b1; n_fph = ph; n_fad = adr;
          n_tgt = LV_NOM; n_prog = LV_NOM; n_st = S_RAIL;
        end else if (last) begin
          n_tgt = (ph == LV_HI) ? LV_LO : LV_NOM;
          n_prog = n_tgt; n_st = S_RAIL;
        end else n_adr = adr + 1'b1;
      default: n_st = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; adr <= '0; pc <= '0; ph <= PH_P1; tgt <= LV_NOM;
      core <= LV_NOM; prog <= LV_NOM; bad <= 1'b0; done <= 1'b0; fail <= 1'b0;
      fail_phase <= PH_P1; fail_addr <= '0;
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end else begin
      st <= n_st; tmr <= span(n_st); adr <= n_adr; pc <= n_pc; ph <= n_ph;
      tgt <= n_tgt; core <= n_core; prog <= n_prog; bad <= n_bad;
      done <= n_done; fail <= n_fail; fail_phase <= n_fph; fail_addr <= n_fad;
    end
  end

  AST_STROBE_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n && rom_oe_n) |-> (core_lvl == LV_PRG && prog_lvl == LV_PRG && rom_wdata_en)); // R3
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> !rom_wdata_en); // R5
  AST_STROBE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n && rom_oe_n && !$past(rom_ce_n)) |-> ($stable(rom_addr) && $stable(rom_wdata))); // R4
  AST_PROG_AFTER_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_lvl == LV_PRG && $past(prog_lvl) != LV_PRG) |-> $past(core_lvl) == LV_PRG); // R2
  AST_CORE_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(core_lvl) == LV_PRG && core_lvl != LV_PRG) |-> $past(prog_lvl) != LV_PRG); // R2
  AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PUL && ph == PH_P1) |-> pc < PW'(MAX_PULSES)); // R6
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail)); // R9

endmodule

// File: tb/eprom_burn_seq_tb_top.sv
module eprom_burn_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_PULSE  = 125;
  localparam int EXP_SETUP  = 3;
  localparam int EXP_READ   = 1;

  typedef struct packed {
    logic [4:0] need; logic [2:0] sa; logic [4:0] sn;
    logic fd; logic [2:0] fa; logic [1:0] ml; logic [2:0] ma;
    logic ok; logic [1:0] ph; logic [2:0] ea; logic [7:0] np;
  } scn_t;

  localparam scn_t SCN [8] = '{
    '{5'd1, 3'd0, 5'd0,  1'b0, 3'd0, 2'd0, 3'd0, 1'b1, 2'd0, 3'd0, 8'd8},
    '{5'd1, 3'd3, 5'd10, 1'b0, 3'd0, 2'd0, 3'd0, 1'b1, 2'd0, 3'd0, 8'd17},
    '{5'd2, 3'd6, 5'd11, 1'b0, 3'd0, 2'd0, 3'd0, 1'b0, 2'd0, 3'd6, 8'd22},
    '{5'd1, 3'd0, 5'd0,  1'b1, 3'd5, 2'd0, 3'd0, 1'b1, 2'd0, 3'd0, 8'd9},
    '{5'd3, 3'd0, 5'd0,  1'b0, 3'd0, 2'd2, 3'd4, 1'b0, 2'd2, 3'd4, 8'd24},
    '{5'd1, 3'd0, 5'd0,  1'b0, 3'd0, 2'd3, 3'd7, 1'b0, 2'd3, 3'd7, 8'd8},
    '{5'd4, 3'd0, 5'd0,  1'b1, 3'd2, 2'd0, 3'd0, 1'b1, 2'd0, 3'd0, 8'd33},
    '{5'd2, 3'd0, 5'd11, 1'b0, 3'd0, 2'd0, 3'd0, 1'b0, 2'd0, 3'd0, 8'd10}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, fail, rom_wdata_en, rom_ce_n, rom_oe_n;
  logic [1:0] fail_phase, core_lvl, prog_lvl;
  logic [2:0] fail_addr, rom_addr;
  logic [7:0] src_data, rom_wdata, rom_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  eprom_burn_seq #(.CLK_HZ(2_500_000), .ADDR_W(3), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
    .fail_phase(fail_phase), .fail_addr(fail_addr), .rom_addr(rom_addr),
    .src_data(src_data), .rom_wdata(rom_wdata), .rom_wdata_en(rom_wdata_en),
    .rom_rdata(rom_rdata), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
    .core_lvl(core_lvl), .prog_lvl(prog_lvl));

  logic [7:0] mem [8];
  int cnt [8];
  int need [8];
  bit fade_en, fade_done;
  logic [2:0] fade_a, marg_a;
  int marg_lvl;
  int total = 0, bad = 0;
  int pulses, setup_bad, hold_bad, wid_bad, read_bad, rail_bad;
  int addr_age = 0, prog_age = 0, wid = 0, hold_age = 0, rd_run = 0;
  logic p_ce = 1'b1, p_oe = 1'b1;
  logic [2:0] p_addr = '0;
  logic [7:0] p_wd = '0;
  logic [1:0] p_core = '0, p_prog = '0;

  assign src_data = 8'h3C ^ (rom_addr * 8'd29);

  always_comb begin
    logic flip;
    flip = (rom_addr == marg_a) &&
           ((marg_lvl == 2 && core_lvl[1]) || (marg_lvl == 3 && core_lvl == 2'b11));
    rom_rdata = mem[rom_addr] ^ {7'd0, flip};
  end

  always @(negedge clk) begin
    logic moved;
    if (rst_n) begin
      moved = (rom_addr != p_addr) || (rom_wdata != p_wd);
      addr_age = moved ? 0 : addr_age + 1;
      prog_age = (prog_lvl != p_prog) ? 0 : prog_age + 1;
      if (prog_lvl == 2'b01 && p_prog != 2'b01 && p_core != 2'b01) rail_bad++;
      if (core_lvl != p_core && prog_lvl != p_prog) rail_bad++;
      if (core_lvl != p_core && core_lvl != 2'b01 && prog_lvl != core_lvl) rail_bad++;
      if (p_ce && !rom_ce_n && rom_oe_n) begin
        pulses++; wid = 1;
        if (addr_age < EXP_SETUP || prog_age < EXP_SETUP || !rom_wdata_en) setup_bad++;
        if (core_lvl != 2'b01 || prog_lvl != 2'b01) rail_bad++;
      end else if (!p_ce && !rom_ce_n && rom_oe_n) begin
        wid++;
        if (moved) hold_bad++;
      end
      if (!p_ce && rom_ce_n && p_oe) begin
        if (wid != EXP_PULSE) wid_bad++;
        hold_age = 1;
        cnt[rom_addr]++;
        if (cnt[rom_addr] >= need[rom_addr]) mem[rom_addr] = mem[rom_addr] & rom_wdata;
      end else if (hold_age != 0) begin
        hold_age = (hold_age >= EXP_SETUP) ? 0 : hold_age + 1;
      end
      if (hold_age != 0 && (moved || !rom_wdata_en)) hold_bad++;
      if (rd_run != 0 && (rom_oe_n || moved || rom_ce_n != p_ce)) begin
        if (rd_run != EXP_READ) read_bad++;
        rd_run = 0;
      end
      if (!rom_oe_n) begin
        rd_run++;
        if (rom_wdata_en) read_bad++;
      end
      if (fade_en && !fade_done && !rom_oe_n && rom_addr == 3'd0 && cnt[fade_a] >= need[fade_a]) begin
        mem[fade_a] = 8'hFF; cnt[fade_a] = need[fade_a] - 1; fade_done = 1'b1;
      end
      p_ce = rom_ce_n; p_oe = rom_oe_n; p_addr = rom_addr; p_wd = rom_wdata;
      p_core = core_lvl; p_prog = prog_lvl;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_scn(input int i, input bit restart);
    scn_t s;
    int wd;
    s = SCN[i];
    for (int k = 0; k < 8; k++) begin
      mem[k] = 8'hFF; cnt[k] = 0; need[k] = int'(s.need);
    end
    if (s.sn != 0) need[s.sa] = int'(s.sn);
    fade_en = s.fd; fade_a = s.fa; fade_done = 1'b0;
    marg_lvl = int'(s.ml); marg_a = s.ma;
    pulses = 0; setup_bad = 0; hold_bad = 0; wid_bad = 0; read_bad = 0; rail_bad = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy && !done && !fail, "R1", "busy after start", int'(busy), 1);
    chk(core_lvl == 2'b01 && prog_lvl == 2'b00, "R2", "core raised first", int'({core_lvl, prog_lvl}), 4);
    if (restart) begin
      repeat (400) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    wd = 0;
    while (!(done || fail) && wd < 60000) begin
      @(negedge clk);
      wd++;
    end
    chk(wd < 60000, "R9", "watchdog", wd, 0);
    chk(done == s.ok && fail == !s.ok, "R9", "result", int'({done, fail}), s.ok ? 2 : 1);
    chk(!busy && core_lvl == 2'b00 && prog_lvl == 2'b00, "R9", "rails home", int'({busy, core_lvl, prog_lvl}), 0);
    if (!s.ok) begin
      chk(fail_phase == s.ph, s.ph == 2'd0 ? "R6" : "R8", "fail_phase", int'(fail_phase), int'(s.ph));
      chk(fail_addr == s.ea, s.ph == 2'd0 ? "R6" : "R8", "fail_addr", int'(fail_addr), int'(s.ea));
    end
    chk(pulses == int'(s.np), restart ? "R1" : (s.fd ? "R7" : "R5"), "strobe count", pulses, int'(s.np));
    chk(wid_bad == 0, "R3", "strobe width (R11 rounding)", wid_bad, 0);
    chk(setup_bad == 0, "R4", "setup before strobe (R11)", setup_bad, 0);
    chk(hold_bad == 0, "R4", "hold after strobe", hold_bad, 0);
    chk(read_bad == 0, "R5", "read window", read_bad, 0);
    chk(rail_bad == 0, "R2", "rail ordering", rail_bad, 0);
    if (i == 0 && !restart) begin
      repeat (20) @(negedge clk);
      chk(done && !busy, "R9", "result held", int'({done, busy}), 2);
    end
  endtask

  initial begin
    marg_lvl = 0; marg_a = '0; fade_en = 1'b0; fade_a = '0; fade_done = 1'b0;
    for (int k = 0; k < 8; k++) begin mem[k] = 8'hFF; cnt[k] = 0; need[k] = 1; end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail, "R10", "status in reset", int'({busy, done, fail}), 0);
    chk(rom_ce_n && rom_oe_n && !rom_wdata_en, "R10", "strobes in reset", int'({rom_ce_n, rom_oe_n, rom_wdata_en}), 6);
    chk(core_lvl == 2'b00 && prog_lvl == 2'b00, "R10", "rails in reset", int'({core_lvl, prog_lvl}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy, "R10", "idle after reset", int'(busy), 0);
    for (int i = 0; i < 8; i++) run_scn(i, 1'b0);
    run_scn(0, 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule